// File: doc/BRIEF.md
# Subnormal single-to-double normalizer

This block takes a 32-bit single-precision word and, when that word is subnormal, produces the same value as a normalized 64-bit double. The double is delivered as two 32-bit words, each written to its own register of a destination pair. The fraction is normalized by a loop that shifts it left by one bit per clock. On each shift the working exponent drops by one, and the loop stops when the implicit leading bit appears. No rounding stage is needed, because every single-precision subnormal fits exactly in a double.

A request is a one-cycle `start` pulse, qualified by the source word and a destination register index. The controller has three states:

- **IDLE**: waits for `start`. On an accepted request it moves to SHIFT when the input is subnormal, and to BYPASS otherwise.
- **SHIFT**: shifts one bit per clock while the leading bit is clear. When the leading bit is set it writes both words, pulses `done`, and returns to IDLE.
- **BYPASS**: lasts one cycle. It pulses `done` without writing and returns to IDLE.

`busy` is high in every state except IDLE, and a `start` seen while `busy` is high is dropped.

Top module: `sub2dbl_norm`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all low.
- R2: An input is treated as subnormal only when bits 30:23 are all zero and bits 22:0 are not all zero; only such inputs are normalized and written.
- R3: A non-subnormal input raises `done` in the first cycle after the accepting edge, keeps `wr_en` low, and leaves the destination pair untouched.
- R4: A subnormal input is shifted one bit per clock. With s = 23 minus the index of its highest set bit among bits 22:0 (so s is 1 to 23), `done` rises in cycle s+1 after the accepting edge.
- R5: The high word has bit 31 equal to the input sign bit. Bits 30:20 hold the exponent 897 - s. Bits 19:0 hold bits 22:3 of the normalized fraction, which excludes the implicit bit.
- R6: The low word carries normalized fraction bits 2:0 in its bits 31:29, and zero in bits 28:0.
- R7: The high word goes to register `dst_idx`, and the low word to register `dst_idx`+1 modulo 16.
- R8: `done` is high for exactly one cycle per accepted request, and `wr_en` is high only in that cycle.
- R9: A `start` that arrives while `busy` is high, including the `done` cycle, is ignored. The running request completes with its own data and index, and no further `done` follows.
- R10: Negative zero (0x80000000) is not subnormal and takes the bypass path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted in IDLE |
| src_word | input | 32 | Single-precision source value |
| dst_idx | input | 4 | Index of the destination pair's first register |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Write strobe for both destination registers |
| wr_hi_idx | output | 4 | Register index for the high word |
| wr_lo_idx | output | 4 | Register index for the low word |
| wr_hi_data | output | 32 | Sign, exponent and upper fraction of the double |
| wr_lo_data | output | 32 | Lower fraction of the double |

## Verification
The bench drives the extremes of the shift count, from a single shift at 0x00400000 and 0x007FFFFF up to 23 shifts at 0x00000001. A design that miscounts those shifts returns `done` one cycle early or late, or carries a stale implicit bit into the fraction. Negative zero and the smallest normal value are the two inputs that sit at the edge of the subnormal test: treating either one as subnormal either hangs the shift loop or writes a value that should have been left alone. A destination index of 15 checks that the low-word index wraps to 0. A second `start` placed inside a running request, and again inside its `done` cycle, would corrupt the result or produce a spurious second completion if it were accepted.

// File: rtl/sdn_pkg.sv
package sdn_pkg;
    localparam int WORD_W    = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int SP_BIAS   = 127;
    localparam int DP_BIAS   = 1023;
    // exponent of a subnormal single rebased to double, before any shift
    localparam int EXP_START = DP_BIAS - (SP_BIAS - 1);
    localparam int EXP_FLOOR = EXP_START - SP_FRAC_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_BYPASS = 2'd2
    } sdn_state_e;
endpackage

// File: rtl/sdn_classify.sv
module sdn_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int IN_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [IN_W-1:0]   word,
    output logic              is_sub,
    output logic              sign,
    output logic [FRAC_W-1:0] frac
);
    logic exp_zero;
    logic frac_nz;

    always_comb begin
        sign     = word[IN_W-1];
        frac     = word[FRAC_W-1:0];
        exp_zero = (word[IN_W-2:FRAC_W] == '0);
        frac_nz  = (frac != '0);
        // sign-only inputs (negative zero) fall out here: no fraction bit set
        is_sub   = exp_zero && frac_nz;
    end
endmodule

// File: rtl/sdn_shifter.sv
module sdn_shifter #(
    parameter int FRAC_W    = 23,
    parameter int EXP_W     = 11,
    parameter int EXP_START = 897,
    localparam int MANT_W   = FRAC_W + 1,
    localparam int EXP_LO   = EXP_START - FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [FRAC_W-1:0] frac_in,
    output logic [FRAC_W-1:0] frac_out,
    output logic [EXP_W-1:0]  exp_out,
    output logic              hidden
);
    logic [MANT_W-1:0] mant_q;
    logic [EXP_W-1:0]  exp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mant_q <= '0;
            exp_q  <= '0;
        end else if (load) begin
            mant_q <= {1'b0, frac_in};
            exp_q  <= EXP_W'(EXP_START);
        end else if (shift) begin
            mant_q <= {mant_q[MANT_W-2:0], 1'b0};
            exp_q  <= exp_q - EXP_W'(1);
        end
    end

    always_comb begin
        hidden   = mant_q[MANT_W-1];
        frac_out = mant_q[FRAC_W-1:0];
        exp_out  = exp_q;
    end

    // R4: each shift step lowers the exponent by exactly one
    a_r4_exp_step: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (exp_q == $past(exp_q) - EXP_W'(1)));

    // R4: a loaded fraction starts at the rebased exponent with no leading bit
    a_r4_load_start: assert property (@(posedge clk) disable iff (!rst_n)
        (load && frac_in != '0) |=> (exp_q == EXP_W'(EXP_START) && !hidden));

    // R5: the loop never runs past 23 shifts for a nonzero fraction
    a_r5_exp_floor: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (exp_q > EXP_W'(EXP_LO)));
endmodule

// File: rtl/sdn_pack.sv
module sdn_pack #(
    parameter int FRAC_W  = 23,
    parameter int EXP_W   = 11,
    parameter int WORD_W  = 32,
    localparam int HI_F_W = WORD_W - 1 - EXP_W,
    localparam int LO_F_W = FRAC_W - HI_F_W
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [FRAC_W-1:0] frac,
    output logic [WORD_W-1:0] hi_word,
    output logic [WORD_W-1:0] lo_word
);
    always_comb begin
        hi_word = {sign, exp_in, frac[FRAC_W-1:LO_F_W]};
        lo_word = {frac[LO_F_W-1:0], {(WORD_W-LO_F_W){1'b0}}};
    end
endmodule

// File: rtl/sub2dbl_norm.sv
module sub2dbl_norm #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       src_word,
    input  logic [ADDR_W-1:0] dst_idx,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_hi_idx,
    output logic [ADDR_W-1:0] wr_lo_idx,
    output logic [31:0]       wr_hi_data,
    output logic [31:0]       wr_lo_data
);
    import sdn_pkg::*;

    localparam int EXP_MSB = WORD_W - 2;
    localparam int EXP_LSB = WORD_W - 1 - DP_EXP_W;
    localparam int LO_ZW   = WORD_W - (SP_FRAC_W - (WORD_W - 1 - DP_EXP_W));

    sdn_state_e state_q, state_d;

    logic                 in_sub, in_sign;
    logic [SP_FRAC_W-1:0] in_frac;
    logic                 accept, load, shift;
    logic                 sign_q;
    logic [ADDR_W-1:0]    idx_q;
    logic [SP_FRAC_W-1:0] norm_frac;
    logic [DP_EXP_W-1:0]  norm_exp;
    logic                 hidden;

    sdn_classify #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_classify (
        .word   (src_word),
        .is_sub (in_sub),
        .sign   (in_sign),
        .frac   (in_frac)
    );

    sdn_shifter #(.FRAC_W(SP_FRAC_W), .EXP_W(DP_EXP_W), .EXP_START(EXP_START)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .frac_in  (in_frac),
        .frac_out (norm_frac),
        .exp_out  (norm_exp),
        .hidden   (hidden)
    );

    sdn_pack #(.FRAC_W(SP_FRAC_W), .EXP_W(DP_EXP_W), .WORD_W(WORD_W)) u_pack (
        .sign    (sign_q),
        .exp_in  (norm_exp),
        .frac    (norm_frac),
        .hi_word (wr_hi_data),
        .lo_word (wr_lo_data)
    );

    always_comb begin
        accept = start && (state_q == ST_IDLE);
        load   = accept && in_sub;
        shift  = (state_q == ST_SHIFT) && !hidden;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = in_sub ? ST_SHIFT : ST_BYPASS;
            ST_SHIFT:  if (hidden) state_d = ST_IDLE;
            ST_BYPASS: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sign_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                sign_q <= in_sign;
                idx_q  <= dst_idx;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        wr_en     = 1'b0;
        wr_hi_idx = idx_q;
        wr_lo_idx = idx_q + ADDR_W'(1);
        unique case (state_q)
            ST_IDLE:   ;
            ST_SHIFT: begin
                busy  = 1'b1;
                done  = hidden;
                wr_en = hidden;
            end
            ST_BYPASS: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default:   ;
        endcase
    end

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: writes only happen alongside completion
    a_r8_wr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);

    // R9: destination index is frozen while a request runs
    a_r9_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wr_hi_idx));

    // R5: a written double always carries a normal exponent
    a_r5_exp_normal: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_hi_data[EXP_MSB:EXP_LSB] != '0));

    // R6: low word padding is zero
    a_r6_lo_pad: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_lo_data[LO_ZW-1:0] == '0));

    // R3: the bypass path never writes
    a_r3_bypass_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS) |-> !wr_en);
endmodule

// File: tb/sub2dbl_norm_tb.sv
module sub2dbl_norm_tb;
    localparam int CLK_P = 10;
    localparam int NV = 12;

    localparam logic [31:0] VEC_SRC [0:NV-1] = '{
        32'h00400000, 32'h007FFFFF, 32'h00000001, 32'h80000001,
        32'h00000100, 32'h80012345, 32'h00000003, 32'h00000000,
        32'h80000000, 32'h3F800000, 32'h7F800000, 32'h00800000 };
    localparam logic [3:0] VEC_DST [0:NV-1] = '{
        4'd3, 4'd0, 4'd5, 4'd15, 4'd7, 4'd2, 4'd9, 4'd4,
        4'd6, 4'd1, 4'd8, 4'd2 };
    localparam int VEC_LAT [0:NV-1] = '{
        2, 2, 24, 24, 16, 8, 23, 1, 1, 1, 1, 1 };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] src_word = '0;
    logic [3:0]  dst_idx = '0;
    logic busy, done, wr_en;
    logic [3:0]  wr_hi_idx, wr_lo_idx;
    logic [31:0] wr_hi_data, wr_lo_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    sub2dbl_norm u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_word(src_word),
        .dst_idx(dst_idx), .busy(busy), .done(done), .wr_en(wr_en),
        .wr_hi_idx(wr_hi_idx), .wr_lo_idx(wr_lo_idx),
        .wr_hi_data(wr_hi_data), .wr_lo_data(wr_lo_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    function automatic void model(input logic [31:0] s, output logic sub,
                                  output logic [31:0] hi, output logic [31:0] lo);
        int p;
        int sh;
        logic [23:0] t;
        logic [10:0] e;
        p = -1;
        for (int i = 0; i < 23; i++) if (s[i]) p = i;
        sub = (s[30:23] == 8'd0) && (p >= 0);
        sh = 23 - p;
        t = {1'b0, s[22:0]} << sh;
        e = 11'(897 - sh);
        hi = {s[31], e, t[22:3]};
        lo = {t[2:0], 29'd0};
    endfunction

    task automatic run_op(input logic [31:0] s, input logic [3:0] d, input int lat);
        int cyc;
        int stray;
        logic sub;
        logic [31:0] ehi, elo;
        model(s, sub, ehi, elo);
        @(negedge clk);
        start = 1'b1; src_word = s; dst_idx = d;
        @(negedge clk);
        start = 1'b0;
        cyc = 1; stray = 0;
        while (!done && cyc < 64) begin
            if (wr_en) stray++;
            @(negedge clk);
            cyc++;
        end
        check("R4/R3 latency", 32'(cyc), 32'(lat));
        check("R8 no write before done", 32'(stray), 32'd0);
        check("R2/R3/R10 write strobe", {31'd0, wr_en}, {31'd0, sub});
        if (sub) begin
            check("R5 high word", wr_hi_data, ehi);
            check("R6 low word", wr_lo_data, elo);
            check("R7 high index", {28'd0, wr_hi_idx}, {28'd0, d});
            check("R7 low index", {28'd0, wr_lo_idx}, {28'd0, 4'(d + 4'd1)});
        end
        @(negedge clk);
        check("R8 done single cycle", {31'd0, done}, 32'd0);
        check("R3 idle after op", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 wr_en", {31'd0, wr_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) run_op(VEC_SRC[v], VEC_DST[v], VEC_LAT[v]);

        // R5 literal values, hand derived
        begin
            logic sub;
            logic [31:0] h, l;
            model(32'h00400000, sub, h, l);
            check("R5 literal 0x00400000", h, 32'h38000000);
            model(32'h80000001, sub, h, l);
            check("R5 literal 0x80000001", h, 32'hB6A00000);
        end

        // R9: start while busy and in the done cycle is dropped
        begin
            int cyc;
            int dones;
            @(negedge clk);
            start = 1'b1; src_word = 32'h00000001; dst_idx = 4'd10;
            @(negedge clk);
            start = 1'b0;
            cyc = 1;
            while (!done && cyc < 64) begin
                if (cyc == 3) begin
                    start = 1'b1; src_word = 32'h00400000; dst_idx = 4'd3;
                end else start = 1'b0;
                @(negedge clk);
                cyc++;
            end
            check("R9 latency of first request", 32'(cyc), 32'd24);
            check("R9 data of first request", wr_hi_data, 32'h36A00000);
            check("R9 index of first request", {28'd0, wr_hi_idx}, 32'd10);
            // start during the done cycle
            start = 1'b1; src_word = 32'h007FFFFF; dst_idx = 4'd1;
            @(negedge clk);
            start = 1'b0;
            dones = 0;
            for (int k = 0; k < 30; k++) begin
                if (done) dones++;
                @(negedge clk);
            end
            check("R9 no extra completion", 32'(dones), 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule